// File: doc/BRIEF.md
# Expansion Window Address Allocator

This block hands out address space inside a fixed 8 MB expansion window, from $200000 up to $9FFFFF. The window is shared by plug-in boards. Each board offers one or more configuration units on a daisy chain. Every unit asks for a power-of-two amount of space. Units are served strictly in the order the chain presents them, so units on the processor-slot card, which sit first on the chain, are served before any unit on the expansion bus. A board that needs a size that is not a power of two, such as 6 MB, shows two units: 4 MB followed by 2 MB.

For each request, the allocator picks the lowest free offset in the window that is a multiple of the requested size. It then either grants the unit that base or tells the unit to stay silent. In both cases it moves the chain enable on to the next position. Configuration ends when the allocator sees a request flagged as the last one, or when every unit position has been used. After that, a registered decoder maps any 24-bit address to a one-hot select of the unit that owns it. An address outside the window, or in space that no unit holds, gives an all-zero select.

Top module: `expspace_alloc`

## Requirements
- R1: After reset, `grant_ok`, `grant_deny`, `alloc_done` and `lk_sel` are 0, `grant_idx` is 0, and `unit_en` is one-hot with bit 0 set.
- R2: A size code c on `req_size` (3 bits, 0 to 7) requests 64 KB shifted left by c, so the range runs from 64 KB (code 0) up to 8 MB (code 7).
- R3: An accepted request that fits gives a one-cycle `grant_ok` pulse on the clock edge after `req_valid`. `grant_base` on that pulse is $200000 plus the lowest offset that is a multiple of the requested size and does not overlap any earlier grant.
- R4: An accepted request that fits nowhere gives a one-cycle `grant_deny` pulse with `grant_base` = 0. The denied unit consumes no space, and its select bit never rises.
- R5: Each accepted request is answered by exactly one of `grant_ok` or `grant_deny`. `grant_idx` carries the chain position of the unit being answered; positions count 0, 1, 2 in request order, and denied units use up a position. `unit_en` is one-hot on the next position to be configured.
- R6: `alloc_done` rises on the edge that accepts a request with `req_last` set, or that accepts the NUM_UNITS-th request. Once set, `alloc_done` stays set, `unit_en` is 0, and further requests produce no pulse and change no mapping.
- R7: Once `alloc_done` is set, `lk_sel` shows, one cycle after `lk_addr`, the one-hot bit of the granted unit whose range holds the address. `lk_sel` is 0 for addresses outside $200000 to $9FFFFF and for window space that no unit holds.
- R8: While `alloc_done` is still 0 at a clock edge, including the edge that accepts the final request, the lookup registered at that edge gives `lk_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | The enabled unit presents its request this cycle |
| req_size | input | 3 | Size code: 64 KB shifted left by the code |
| req_last | input | 1 | The request comes from the final unit on the chain |
| unit_en | output | NUM_UNITS | One-hot enable of the chain position awaiting configuration |
| grant_ok | output | 1 | Pulse: the unit received a base |
| grant_deny | output | 1 | Pulse: the unit must stay silent |
| grant_base | output | 24 | Granted base address; 0 on a deny |
| grant_idx | output | clog2(NUM_UNITS) | Chain position being answered |
| alloc_done | output | 1 | Configuration finished |
| lk_addr | input | 24 | Address to decode |
| lk_sel | output | NUM_UNITS | One-hot select of the unit owning `lk_addr` |

## Verification
The final request and an address lookup can land on the same clock edge. This is the one place where a lookup could see a unit table that is only partly finished. The bench provokes this case in every scenario: it holds `lk_addr` at the window base while the final request is presented. It then expects `lk_sel` to be 0 right after that edge, and to be bit 0 one cycle later. The exhaustive sweep over all 512 triples of size codes checks every grant, deny and base against an interval-overlap model that the bench computes on its own. It also probes the window every 256 KB, at both ends of each unit, and just outside the window.

// File: rtl/expalloc_pkg.sv
package expalloc_pkg;
  localparam int ADDR_W    = 24;
  localparam int GRAN_LG   = 16;
  localparam int WIN_LG    = 23;
  localparam int GIDX_W    = WIN_LG - GRAN_LG;
  localparam int WIN_GRANS = 1 << GIDX_W;
  localparam int SZ_W      = 3;
  localparam int NCODE     = 1 << SZ_W;
  localparam logic [ADDR_W-1:0] WIN_BASE = 24'h20_0000;
  localparam logic [ADDR_W:0]   WIN_END  = {1'b0, WIN_BASE} + ((ADDR_W+1)'(1) << WIN_LG);

  typedef struct packed {
    logic              valid;
    logic [GIDX_W-1:0] gbase;
    logic [SZ_W-1:0]   code;
  } unit_rec_t;
endpackage

// File: rtl/expalloc_fit.sv
module expalloc_fit
  import expalloc_pkg::*;
(
  input  logic [WIN_GRANS-1:0] used,
  input  logic [SZ_W-1:0]      code,
  output logic                 fit,
  output logic [GIDX_W-1:0]    slot,
  output logic [WIN_GRANS-1:0] claim
);
  logic              fit_c  [NCODE];
  logic [GIDX_W-1:0] slot_c [NCODE];

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    localparam int LEN   = 1 << c;
    localparam int NSLOT = (LEN <= WIN_GRANS) ? WIN_GRANS / LEN : 1;
    if (LEN <= WIN_GRANS) begin : g_fits
      logic [NSLOT-1:0]  free_s;
      logic              fit_g;
      logic [GIDX_W-1:0] slot_g;
      for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign free_s[k] = ~|used[k*LEN +: LEN];
      end
      // lowest aligned free slot wins: scan downward, last hit kept
      always_comb begin
        fit_g  = 1'b0;
        slot_g = '0;
        for (int k = NSLOT - 1; k >= 0; k--) begin
          if (free_s[k]) begin
            fit_g  = 1'b1;
            slot_g = GIDX_W'(k * LEN);
          end
        end
      end
      assign fit_c[c]  = fit_g;
      assign slot_c[c] = slot_g;
    end else begin : g_big
      assign fit_c[c]  = 1'b0;
      assign slot_c[c] = '0;
    end
  end

  assign fit  = fit_c[code];
  assign slot = slot_c[code];

  always_comb begin
    for (int i = 0; i < WIN_GRANS; i++) begin
      claim[i] = fit && (i >= int'(slot)) && (i < int'(slot) + (1 << code));
    end
  end
endmodule

// File: rtl/expalloc_table.sv
module expalloc_table
  import expalloc_pkg::*;
#(
  parameter  int NUM_UNITS = 4,
  localparam int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [GIDX_W-1:0]    wr_gbase,
  input  logic [SZ_W-1:0]      wr_code,
  input  logic                 lk_en,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic [NUM_UNITS-1:0] lk_sel
);
  unit_rec_t rec_q [NUM_UNITS];
  unit_rec_t rec_d [NUM_UNITS];
  logic [NUM_UNITS-1:0] hit, sel_d;
  logic                 in_win;
  logic [GIDX_W-1:0]    g;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      rec_d[u] = rec_q[u];
      if (wr_en && wr_idx == IDX_W'(u)) begin
        rec_d[u] = '{valid: 1'b1, gbase: wr_gbase, code: wr_code};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int u = 0; u < NUM_UNITS; u++) rec_q[u] <= '0;
    end else if (wr_en) begin
      for (int u = 0; u < NUM_UNITS; u++) rec_q[u] <= rec_d[u];
    end
  end

  assign in_win = (lk_addr >= WIN_BASE) && ({1'b0, lk_addr} < WIN_END);
  assign g      = GIDX_W'((lk_addr - WIN_BASE) >> GRAN_LG);

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      hit[u] = in_win && rec_q[u].valid &&
               ((g >> rec_q[u].code) == (rec_q[u].gbase >> rec_q[u].code));
    end
    sel_d = lk_en ? hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lk_sel <= '0;
    else        lk_sel <= sel_d;
  end

  // granted ranges never overlap, so at most one unit answers
  assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_sel));
endmodule

// File: rtl/expspace_alloc.sv
module expspace_alloc
  import expalloc_pkg::*;
#(
  parameter  int NUM_UNITS = 4,
  localparam int IDX_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [SZ_W-1:0]      req_size,
  input  logic                 req_last,
  output logic [NUM_UNITS-1:0] unit_en,
  output logic                 grant_ok,
  output logic                 grant_deny,
  output logic [ADDR_W-1:0]    grant_base,
  output logic [IDX_W-1:0]     grant_idx,
  output logic                 alloc_done,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic [NUM_UNITS-1:0] lk_sel
);
  logic [1:0] rs_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic [WIN_GRANS-1:0] used_q, used_d, claim;
  logic [IDX_W-1:0]     pos_q, pos_d, gidx_d;
  logic                 done_q, done_d, gok_d, gdeny_d;
  logic [ADDR_W-1:0]    gbase_d;
  logic                 accept, fit, fin;
  logic [GIDX_W-1:0]    slot;

  expalloc_fit u_fit (
    .used  (used_q),
    .code  (req_size),
    .fit   (fit),
    .slot  (slot),
    .claim (claim)
  );

  assign accept = req_valid && !done_q;
  assign fin    = req_last || (pos_q == IDX_W'(NUM_UNITS - 1));

  always_comb begin
    used_d  = used_q | (fit ? claim : '0);
    pos_d   = fin ? pos_q : pos_q + IDX_W'(1);
    done_d  = done_q | fin;
    gok_d   = accept && fit;
    gdeny_d = accept && !fit;
    gbase_d = (accept && fit) ? WIN_BASE + (ADDR_W'(slot) << GRAN_LG) : '0;
    gidx_d  = accept ? pos_q : grant_idx;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      used_q     <= '0;
      pos_q      <= '0;
      done_q     <= 1'b0;
      grant_ok   <= 1'b0;
      grant_deny <= 1'b0;
      grant_base <= '0;
      grant_idx  <= '0;
    end else begin
      grant_ok   <= gok_d;
      grant_deny <= gdeny_d;
      grant_base <= gbase_d;
      grant_idx  <= gidx_d;
      if (accept) begin
        used_q <= used_d;
        pos_q  <= pos_d;
        done_q <= done_d;
      end
    end
  end

  assign alloc_done = done_q;
  assign unit_en    = done_q ? '0 : (NUM_UNITS'(1) << pos_q);

  expalloc_table #(.NUM_UNITS(NUM_UNITS)) u_table (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (accept && fit),
    .wr_idx   (pos_q),
    .wr_gbase (slot),
    .wr_code  (req_size),
    .lk_en    (done_q),
    .lk_addr  (lk_addr),
    .lk_sel   (lk_sel)
  );

  assert_answer_excl_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(grant_ok && grant_deny));
  assert_answer_cause_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (grant_ok || grant_deny) |-> $past(req_valid && !done_q));
  assert_enable_onehot_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(unit_en));
  assert_deny_base_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    grant_deny |-> grant_base == '0);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && fit) |-> (claim & used_q) == '0);
  assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    grant_ok |-> (grant_base >= WIN_BASE) && ({1'b0, grant_base} < WIN_END));
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    alloc_done |=> alloc_done);
  assert_no_early_hit_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$past(done_q) |-> lk_sel == '0);
endmodule

// File: tb/tb_expspace_alloc.sv
module tb_expspace_alloc;
  localparam int NU = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_last;
  logic [2:0]    req_size;
  logic [NU-1:0] unit_en, lk_sel;
  logic          grant_ok, grant_deny, alloc_done;
  logic [23:0]   grant_base, lk_addr;
  logic [1:0]    grant_idx;

  int checks = 0;
  int fails  = 0;

  int eb [NU];
  int esz[NU];
  bit eok[NU];
  int nu;

  always #2 clk = ~clk;

  expspace_alloc #(.NUM_UNITS(NU)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_last(req_last), .unit_en(unit_en), .grant_ok(grant_ok),
    .grant_deny(grant_deny), .grant_base(grant_base), .grant_idx(grant_idx),
    .alloc_done(alloc_done), .lk_addr(lk_addr), .lk_sel(lk_sel)
  );

  task automatic chk(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_last = 1'b0; req_size = '0; lk_addr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    nu = 0;
  endtask

  // independent first-fit model over intervals
  task automatic model_add(int code);
    int s;
    s = 1 << (16 + code);
    eok[nu] = 1'b0; eb[nu] = 0; esz[nu] = s;
    for (int off = 0; off + s <= (1 << 23) && !eok[nu]; off += s) begin
      bit clash = 1'b0;
      for (int i = 0; i < nu; i++)
        if (eok[i] && off < eb[i] + esz[i] && eb[i] < off + s) clash = 1'b1;
      if (!clash) begin eok[nu] = 1'b1; eb[nu] = off; end
    end
    nu++;
  endtask

  function automatic logic [NU-1:0] exp_sel(int addr);
    logic [NU-1:0] r = '0;
    for (int i = 0; i < nu; i++)
      if (eok[i] && addr >= 'h200000 + eb[i] && addr < 'h200000 + eb[i] + esz[i]) r[i] = 1'b1;
    return r;
  endfunction

  task automatic do_req(int code, bit last);
    int j = nu;
    chk(unit_en == NU'(1 << j), "R5 unit_en before request", 32'(unit_en), 32'(1 << j));
    model_add(code);
    @(negedge clk);
    req_valid = 1'b1; req_size = 3'(code); req_last = last;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_last = 1'b0;
    chk(grant_ok == eok[j], "R3 grant_ok", 32'(grant_ok), 32'(eok[j]));
    chk(grant_deny == !eok[j], "R4 grant_deny", 32'(grant_deny), 32'(!eok[j]));
    chk(grant_base == (eok[j] ? 24'('h200000 + eb[j]) : 24'h0), "R3 grant_base",
        32'(grant_base), eok[j] ? 32'('h200000 + eb[j]) : 32'h0);
    chk(grant_idx == 2'(j), "R5 grant_idx", 32'(grant_idx), 32'(j));
  endtask

  task automatic ignored_req(int code);
    @(negedge clk);
    req_valid = 1'b1; req_size = 3'(code); req_last = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_last = 1'b0;
    chk(!grant_ok && !grant_deny, "R6 request after done ignored",
        32'({grant_ok, grant_deny}), 32'h0);
  endtask

  task automatic look(int addr, string tag);
    logic [NU-1:0] e;
    @(negedge clk) lk_addr = 24'(addr);
    @(posedge clk);
    #1;
    e = exp_sel(addr);
    chk(lk_sel == e, tag, 32'(lk_sel), 32'(e));
  endtask

  initial begin
    #(600000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk(!grant_ok && !grant_deny && !alloc_done, "R1 reset pulses and done",
        32'({grant_ok, grant_deny, alloc_done}), 32'h0);
    chk(lk_sel == '0 && grant_idx == '0, "R1 reset select and index",
        32'({lk_sel, grant_idx}), 32'h0);
    chk(unit_en == 4'b0001, "R1 reset enable", 32'(unit_en), 32'h1);

    // exhaustive sweep over three-unit chains
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int c = 0; c < 8; c++) begin
          do_reset();
          lk_addr = 24'h200000;
          do_req(a, 1'b0);
          chk(lk_sel == '0, "R8 lookup during configuration", 32'(lk_sel), 32'h0);
          do_req(b, 1'b0);
          do_req(c, 1'b1);
          chk(lk_sel == '0, "R8 lookup on final edge", 32'(lk_sel), 32'h0);
          chk(alloc_done == 1'b1, "R6 done after last", 32'(alloc_done), 32'h1);
          chk(unit_en == '0, "R6 enable cleared", 32'(unit_en), 32'h0);
          @(posedge clk);
          #1;
          chk(lk_sel == 4'b0001, "R7 lookup right after done", 32'(lk_sel), 32'h1);
          look('h1FFFFF, "R7 below window");
          look('hA00000, "R7 above window");
          look('hFFFFFF, "R7 top of space");
          for (int p = 0; p < 32; p++)
            look('h200000 + p * 'h40000 + ((p % 2) ? 'h3FFFF : 0), "R7 window probe");
          for (int i = 0; i < 3; i++) begin
            look('h200000 + eb[i], "R2 unit first byte");
            look('h200000 + eb[i] + esz[i] - 1, "R2 unit last byte");
          end
          if (c == 0) begin
            ignored_req(0);
            look('h200000 + (1 << 23) - 'h10000, "R6 map unchanged after ignored request");
          end
        end
      end
    end

    // position limit without a last flag; six-megabyte board as 4 MB + 2 MB
    do_reset();
    do_req(6, 1'b0);
    do_req(5, 1'b0);
    do_req(0, 1'b0);
    chk(alloc_done == 1'b0, "R6 not done before limit", 32'(alloc_done), 32'h0);
    do_req(0, 1'b0);
    chk(alloc_done == 1'b1, "R6 done at unit limit", 32'(alloc_done), 32'h1);
    chk(eb[0] == 0 && eb[1] == 'h400000, "R3 split board bases", 32'(eb[1]), 32'h400000);
    ignored_req(0);
    look('h820000, "R6 space after limit stays free");
    look('h5FFFFF, "R7 split board low part");
    look('h600000, "R7 split board high part");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule